// File: doc/BRIEF.md
# Chunked Memory Copy Sequencer

This block is the data-moving engine behind a single DMA channel. Software-facing logic elsewhere holds a pending descriptor: source address, destination address, byte count, a read-size exponent, a write-size exponent and a repeat flag. It pulses `start`. The engine then checks the descriptor and copies it into its working (exec) registers. It then copies memory in transactions whose length is a power of two, capped at 64 bytes. A shorter transaction at the end carries whatever bytes are left.

Each transaction is a read request on the read port, followed by the returned data beats, which are collected in a 64-byte internal buffer. The buffer is then emptied through the write port, beat by beat. When the last write beat of a transaction is accepted, the exec source and destination advance and the remaining count drops. The exec registers can be observed at any time. The completion status is done or error, and a two-bit channel state tracks the progress of the transfer.

Top module: `chunk_copy_engine`

## Requirements
- R1: A start with a descriptor byte count of zero sets done and chan_state=3 (done) in the next cycle. It issues no read or write request and leaves the exec registers unchanged.
- R2: A start whose write-size exponent differs from its read-size exponent sets err, clears done and sets chan_state=2 (error) in the next cycle. It issues no memory request and leaves the exec registers unchanged.
- R3: Every transaction length equals 2^min(exponent,6) bytes, except the final shorter one. The length is given on rd_len and wr_len, and is never 0 and never above 64.
- R4: For a count N and a full size S, the engine issues floor(N/S) transactions of S bytes. If N is not a multiple of S, one further transaction of N mod S bytes follows. The read and write lengths of each transaction are equal.
- R5: An accepted start with a nonzero count and matching exponents loads the exec source, destination, count, both exponents and repeat from the descriptor. In the next cycle it sets busy, clears done and err, and sets chan_state=1 (started). Done and err stay low while busy.
- R6: After the last write beat of a transaction that is not the final one, exec_src and exec_dst have both risen by the transaction length, and exec_bytes has fallen by that length.
- R7: When repeat is set, at completion exec_src, exec_dst and exec_bytes hold the values loaded at start. Without repeat, they hold source+N, destination+N and 0.
- R8: At completion, busy drops, done rises and chan_state=3. Done and err are never high together.
- R9: A start pulse that arrives while busy is ignored. The transfer in progress continues, and done stays low.
- R10: A request is held stable until it is accepted, and only one of rd_valid and wr_valid is high at a time. In transaction beat k, bytes 8k..8k+7 of that transaction are carried, with the lowest address in data bits 7:0. The destination receives exactly N bytes equal to the source, and the byte just past the destination region is not written.
- R11: After reset, busy, done, err, rd_valid and wr_valid are low, and chan_state=0 (idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, honoured only when idle |
| desc_src | input | 64 | Pending source address |
| desc_dst | input | 64 | Pending destination address |
| desc_bytes | input | 64 | Pending byte count |
| desc_wr_lg2 | input | 4 | Pending write-size exponent |
| desc_rd_lg2 | input | 4 | Pending read-size exponent |
| desc_repeat | input | 1 | Pending repeat flag |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 64 | Read transaction start address |
| rd_len | output | 7 | Read transaction length in bytes |
| rd_rvalid | input | 1 | Read data beat valid |
| rd_rdata | input | 64 | Read data beat |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | 64 | Write transaction start address |
| wr_len | output | 7 | Write transaction length in bytes |
| wr_data | output | 64 | Write data beat |
| wr_last | output | 1 | Last beat of the transaction |
| busy | output | 1 | Transfer in progress (run) |
| done | output | 1 | Completion status |
| err | output | 1 | Error status |
| chan_state | output | 2 | 0 idle, 1 started, 2 error, 3 done |
| exec_src | output | 64 | Working source address |
| exec_dst | output | 64 | Working destination address |
| exec_bytes | output | 64 | Working remaining count |
| exec_wr_lg2 | output | 4 | Working write exponent |
| exec_rd_lg2 | output | 4 | Working read exponent |
| exec_repeat | output | 1 | Working repeat flag |

## Verification
A beat index that is off by one shows up within one transaction. Wrong data or a missing last beat appears at the destination, and the buffer is checked byte by byte against a copy of the source. A wrong advance or a wrong size cap shows up at the very next read request, as a wrong address or length. The bench checks every exec update one cycle after the closing write beat, and compares the list of transaction lengths with the list computed for each count and exponent. A repeat reload that uses a wrong base is visible on the exec ports as soon as done rises.

// File: rtl/ccopy_pkg.sv
// Shared types for the chunked copy sequencer.
package ccopy_pkg;
    // Externally visible channel state, values fixed by the port contract.
    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_STARTED = 2'd1,
        CS_ERROR   = 2'd2,
        CS_DONE    = 2'd3
    } chan_state_t;

    // Internal transaction phase.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RDREQ,
        PH_RDDATA,
        PH_WRDATA
    } phase_t;
endpackage

// File: rtl/ccopy_sizer.sv
// Transaction sizer: derives the length of the next transaction from the
// remaining count and the size exponent, and the number of data beats.
// Assumes remaining is nonzero whenever the result is used.
module ccopy_sizer #(
    parameter int CNT_W   = 64,
    parameter int MAX_LG2 = 6,
    parameter int BEAT_B  = 8,
    parameter int LEN_W   = MAX_LG2 + 1
) (
    input  logic [CNT_W-1:0] remaining,
    input  logic [3:0]       lg2,
    output logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] beats,
    output logic             last_chunk
);
    localparam int SH = (BEAT_B > 1) ? $clog2(BEAT_B) : 0;

    logic [3:0]       cap;
    logic [LEN_W-1:0] full_size;
    logic [CNT_W-1:0] full_ext;
    logic [LEN_W:0]   rounded;

    // Cap the exponent and form the full transaction size.
    always_comb begin
        cap       = (lg2 > 4'(MAX_LG2)) ? 4'(MAX_LG2) : lg2;
        full_size = LEN_W'(1) << cap;
        full_ext  = CNT_W'(full_size);
    end

    // Pick full size or the tail, and count beats rounding up.
    always_comb begin
        last_chunk = (remaining <= full_ext);
        len        = last_chunk ? remaining[LEN_W-1:0] : full_size;
        rounded    = {1'b0, len} + (LEN_W+1)'(BEAT_B - 1);
        beats      = LEN_W'(rounded >> SH);
    end
endmodule

// File: rtl/ccopy_buffer.sv
// Staging buffer: holds one transaction's data beats between read and write.
// Assumes a beat is never written and read in the same phase.
module ccopy_buffer #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    // Capture an incoming read beat at its slot.
    always_ff @(posedge clk) begin
        if (we) begin
            store[idx] <= wdata;
        end
    end

    // Present the slot addressed by the beat index.
    always_comb begin
        rdata = store[idx];
    end
endmodule

// File: rtl/ccopy_exec_regs.sv
// Exec register file: loads the descriptor at start, advances per
// transaction, and on a repeat finish rebuilds the start values from the
// final pointers minus the original count. Assumes load and adv never
// coincide.
module ccopy_exec_regs #(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 64,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d_src,
    input  logic [ADDR_W-1:0] d_dst,
    input  logic [CNT_W-1:0]  d_bytes,
    input  logic [3:0]        d_wlg,
    input  logic [3:0]        d_rlg,
    input  logic              d_rep,
    input  logic              adv,
    input  logic [LEN_W-1:0]  adv_len,
    input  logic              reload,
    output logic [ADDR_W-1:0] x_src,
    output logic [ADDR_W-1:0] x_dst,
    output logic [CNT_W-1:0]  x_bytes,
    output logic [3:0]        x_wlg,
    output logic [3:0]        x_rlg,
    output logic              x_rep
);
    logic [CNT_W-1:0]  orig_bytes;
    logic [ADDR_W-1:0] step_a;
    logic [ADDR_W-1:0] orig_a;

    // Widen the step and original count for pointer arithmetic.
    always_comb begin
        step_a = ADDR_W'(adv_len);
        orig_a = ADDR_W'(orig_bytes);
    end

    // Load, advance or reload the working registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_src      <= '0;
            x_dst      <= '0;
            x_bytes    <= '0;
            x_wlg      <= '0;
            x_rlg      <= '0;
            x_rep      <= 1'b0;
            orig_bytes <= '0;
        end else if (load) begin
            x_src      <= d_src;
            x_dst      <= d_dst;
            x_bytes    <= d_bytes;
            x_wlg      <= d_wlg;
            x_rlg      <= d_rlg;
            x_rep      <= d_rep;
            orig_bytes <= d_bytes;
        end else if (adv) begin
            if (reload) begin
                x_src   <= x_src + step_a - orig_a;
                x_dst   <= x_dst + step_a - orig_a;
                x_bytes <= orig_bytes;
            end else begin
                x_src   <= x_src + step_a;
                x_dst   <= x_dst + step_a;
                x_bytes <= x_bytes - CNT_W'(adv_len);
            end
        end
    end

    // Source and destination always move by the same distance.
    AST_EQUAL_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((x_src - $past(x_src)) == (x_dst - $past(x_dst)))); // R6

    // A load is never issued mid-transaction.
    AST_NO_LOAD_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && adv)); // R9
endmodule

// File: rtl/ccopy_ctrl.sv
// Sequencer: accepts or rejects a start, walks each transaction through
// request, read beats and write beats, and keeps the status bits.
// Assumes read data beats only arrive after a request is accepted.
module ccopy_ctrl #(
    parameter int LEN_W = 7,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             zero_cnt,
    input  logic             size_mismatch,
    input  logic             rd_ready,
    input  logic             rd_rvalid,
    input  logic             wr_ready,
    input  logic [LEN_W-1:0] beats,
    input  logic             last_chunk,
    input  logic             x_repeat,
    output logic             load,
    output logic             adv,
    output logic             reload,
    output logic             rd_valid,
    output logic             wr_valid,
    output logic             wr_last,
    output logic [IDX_W-1:0] idx,
    output logic             buf_we,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [1:0]       chan_state
);
    import ccopy_pkg::*;

    phase_t      phase;
    chan_state_t cs;
    logic        last_beat;
    logic        accept_go;
    logic        wr_fire_last;

    // Decode the beat position and handshake events.
    always_comb begin
        last_beat    = (LEN_W'(idx) == (beats - LEN_W'(1)));
        accept_go    = (phase == PH_IDLE) && start && !zero_cnt && !size_mismatch;
        wr_fire_last = (phase == PH_WRDATA) && wr_ready && last_beat;
    end

    // Drive handshake and datapath strobes from the phase.
    always_comb begin
        rd_valid   = (phase == PH_RDREQ);
        wr_valid   = (phase == PH_WRDATA);
        wr_last    = wr_valid && last_beat;
        buf_we     = (phase == PH_RDDATA) && rd_rvalid;
        load       = accept_go;
        adv        = wr_fire_last;
        reload     = wr_fire_last && last_chunk && x_repeat;
        busy       = (phase != PH_IDLE);
        chan_state = cs;
    end

    // Phase and beat index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            idx   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept_go) begin
                        phase <= PH_RDREQ;
                    end
                end
                PH_RDREQ: begin
                    if (rd_ready) begin
                        phase <= PH_RDDATA;
                        idx   <= '0;
                    end
                end
                PH_RDDATA: begin
                    if (rd_rvalid) begin
                        if (last_beat) begin
                            phase <= PH_WRDATA;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                default: begin
                    if (wr_ready) begin
                        if (last_beat) begin
                            phase <= last_chunk ? PH_IDLE : PH_RDREQ;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // Completion and error status with the visible channel state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
            cs   <= CS_IDLE;
        end else if ((phase == PH_IDLE) && start) begin
            if (zero_cnt) begin
                done <= 1'b1;
                err  <= 1'b0;
                cs   <= CS_DONE;
            end else if (size_mismatch) begin
                done <= 1'b0;
                err  <= 1'b1;
                cs   <= CS_ERROR;
            end else begin
                done <= 1'b0;
                err  <= 1'b0;
                cs   <= CS_STARTED;
            end
        end else if (wr_fire_last && last_chunk) begin
            done <= 1'b1;
            cs   <= CS_DONE;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_valid && !wr_valid)); // R1
    AST_BUSY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !err && chan_state == 2'd1)); // R5
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid)); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid); // R10
    AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
endmodule

// File: rtl/chunk_copy_engine.sv
// Chunked memory copy sequencer for one DMA channel. Validates a pending
// descriptor on start, then copies in power-of-two transactions capped at
// 2^MAX_LG2 bytes plus one tail, through a staging buffer.
// Assumes rd_rdata beats arrive only after the read request is accepted.
module chunk_copy_engine #(
    parameter int ADDR_W  = 64,
    parameter int CNT_W   = 64,
    parameter int DATA_W  = 64,
    parameter int MAX_LG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic [CNT_W-1:0]  desc_bytes,
    input  logic [3:0]        desc_wr_lg2,
    input  logic [3:0]        desc_rd_lg2,
    input  logic              desc_repeat,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [MAX_LG2:0]  rd_len,
    input  logic              rd_rvalid,
    input  logic [DATA_W-1:0] rd_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [MAX_LG2:0]  wr_len,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        chan_state,
    output logic [ADDR_W-1:0] exec_src,
    output logic [ADDR_W-1:0] exec_dst,
    output logic [CNT_W-1:0]  exec_bytes,
    output logic [3:0]        exec_wr_lg2,
    output logic [3:0]        exec_rd_lg2,
    output logic              exec_repeat
);
    localparam int LEN_W  = MAX_LG2 + 1;
    localparam int BEAT_B = DATA_W / 8;
    localparam int MAX_B  = 1 << MAX_LG2;
    localparam int DEPTH  = (MAX_B + BEAT_B - 1) / BEAT_B;
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             zero_cnt;
    logic             size_mismatch;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] cur_beats;
    logic             last_chunk;
    logic             load;
    logic             adv;
    logic             reload;
    logic             buf_we;
    logic [IDX_W-1:0] idx;

    // Classify the pending descriptor.
    always_comb begin
        zero_cnt      = (desc_bytes == '0);
        size_mismatch = (desc_wr_lg2 != desc_rd_lg2);
    end

    // Both ports address from the exec pointers with the current length.
    always_comb begin
        rd_addr = exec_src;
        wr_addr = exec_dst;
        rd_len  = cur_len;
        wr_len  = cur_len;
    end

    ccopy_sizer #(
        .CNT_W(CNT_W), .MAX_LG2(MAX_LG2), .BEAT_B(BEAT_B), .LEN_W(LEN_W)
    ) u_sizer (
        .remaining (exec_bytes),
        .lg2       (exec_wr_lg2),
        .len       (cur_len),
        .beats     (cur_beats),
        .last_chunk(last_chunk)
    );

    ccopy_exec_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_exec (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .d_src  (desc_src),
        .d_dst  (desc_dst),
        .d_bytes(desc_bytes),
        .d_wlg  (desc_wr_lg2),
        .d_rlg  (desc_rd_lg2),
        .d_rep  (desc_repeat),
        .adv    (adv),
        .adv_len(cur_len),
        .reload (reload),
        .x_src  (exec_src),
        .x_dst  (exec_dst),
        .x_bytes(exec_bytes),
        .x_wlg  (exec_wr_lg2),
        .x_rlg  (exec_rd_lg2),
        .x_rep  (exec_repeat)
    );

    ccopy_buffer #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
    ) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .idx  (idx),
        .wdata(rd_rdata),
        .rdata(wr_data)
    );

    ccopy_ctrl #(
        .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .zero_cnt     (zero_cnt),
        .size_mismatch(size_mismatch),
        .rd_ready     (rd_ready),
        .rd_rvalid    (rd_rvalid),
        .wr_ready     (wr_ready),
        .beats        (cur_beats),
        .last_chunk   (last_chunk),
        .x_repeat     (exec_repeat),
        .load         (load),
        .adv          (adv),
        .reload       (reload),
        .rd_valid     (rd_valid),
        .wr_valid     (wr_valid),
        .wr_last      (wr_last),
        .idx          (idx),
        .buf_we       (buf_we),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .chan_state   (chan_state)
    );

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |-> (rd_len != '0 && int'(rd_len) <= MAX_B)); // R3
    AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> ($stable(rd_addr) && $stable(rd_len))); // R10
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_last))); // R10
endmodule

// File: tb/chunk_copy_engine_tb.sv
module chunk_copy_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_B      = 4096;
    localparam int LOG_N      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] desc_src = '0, desc_dst = '0, desc_bytes = '0;
    logic [3:0]  desc_wr_lg2 = '0, desc_rd_lg2 = '0;
    logic        desc_repeat = 1'b0;
    logic        rd_valid, rd_ready, rd_rvalid;
    logic [63:0] rd_addr, rd_rdata;
    logic [6:0]  rd_len, wr_len;
    logic        wr_valid, wr_ready, wr_last;
    logic [63:0] wr_addr, wr_data;
    logic        busy, done, err;
    logic [1:0]  chan_state;
    logic [63:0] exec_src, exec_dst, exec_bytes;
    logic [3:0]  exec_wr_lg2, exec_rd_lg2;
    logic        exec_repeat;

    chunk_copy_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_bytes(desc_bytes),
        .desc_wr_lg2(desc_wr_lg2), .desc_rd_lg2(desc_rd_lg2), .desc_repeat(desc_repeat),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
        .wr_data(wr_data), .wr_last(wr_last),
        .busy(busy), .done(done), .err(err), .chan_state(chan_state),
        .exec_src(exec_src), .exec_dst(exec_dst), .exec_bytes(exec_bytes),
        .exec_wr_lg2(exec_wr_lg2), .exec_rd_lg2(exec_rd_lg2), .exec_repeat(exec_repeat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] mem  [MEM_B];
    logic [7:0] gold [MEM_B];
    int unsigned rlens [LOG_N];
    int unsigned wlens [LOG_N];
    int unsigned rl_n, wl_n, acc_n;
    int tests = 0, fails = 0;
    int unsigned pend, rk, wk;
    logic [63:0] rbase;
    bit adv_chk;
    logic [63:0] exp_s, exp_d, exp_b;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned full_sz(input int unsigned lg);
        return 1 << ((lg > 6) ? 6 : lg);
    endfunction

    // Memory-side responders, driven and sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ready = 1'b0; rd_rvalid = 1'b0; rd_rdata = '0; wr_ready = 1'b0;
            pend = 0; rk = 0; wk = 0; adv_chk = 1'b0;
        end else begin
            if (adv_chk) begin
                adv_chk = 1'b0;
                chk(exec_src == exp_s && exec_dst == exp_d && exec_bytes == exp_b,
                    "R6 advance", exec_bytes, exp_b);
            end
            if (pend > 0 && $urandom_range(0, 3) != 0) begin
                rd_rvalid = 1'b1;
                for (int b = 0; b < 8; b++)
                    rd_rdata[8*b +: 8] = mem[(rbase + 64'(8*rk + b)) % MEM_B];
                rk++; pend--;
            end else begin
                rd_rvalid = 1'b0;
            end
            rd_ready = ($urandom_range(0, 3) != 0);
            if (rd_valid && rd_ready) begin
                if (rl_n < LOG_N) rlens[rl_n] = rd_len;
                rl_n++; acc_n++;
                pend = (rd_len + 7) / 8; rk = 0; rbase = rd_addr;
            end
            wr_ready = ($urandom_range(0, 3) != 0);
            if (wr_valid && wr_ready) begin
                acc_n++;
                for (int b = 0; b < 8; b++)
                    if (8*wk + b < wr_len)
                        mem[(wr_addr + 64'(8*wk + b)) % MEM_B] = wr_data[8*b +: 8];
                if (wr_last) begin
                    if (wl_n < LOG_N) wlens[wl_n] = wr_len;
                    wl_n++; wk = 0;
                    if (exec_bytes != 64'(wr_len)) begin
                        adv_chk = 1'b1;
                        exp_s = exec_src + 64'(wr_len);
                        exp_d = exec_dst + 64'(wr_len);
                        exp_b = exec_bytes - 64'(wr_len);
                    end
                end else begin
                    wk++;
                end
            end
        end
    end

    task automatic run_xfer(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                            input logic [3:0] wl, input logic [3:0] rl, input bit rep, input bit poke);
        logic [63:0] ps, pd, pb;
        bit ok;
        int unsigned sz, nexp, rem;
        for (int i = 0; i < MEM_B; i++) gold[i] = mem[i];
        rl_n = 0; wl_n = 0; acc_n = 0;
        @(negedge clk);
        ps = exec_src; pd = exec_dst; pb = exec_bytes;
        desc_src = s; desc_dst = d; desc_bytes = n;
        desc_wr_lg2 = wl; desc_rd_lg2 = rl; desc_repeat = rep; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done && !err && !busy && chan_state == 2'd3, "R1 zero-count done", {62'd0, chan_state}, 64'd3);
            chk(exec_src == ps && exec_bytes == pb, "R1 exec untouched", exec_bytes, pb);
            repeat (4) @(negedge clk);
            chk(acc_n == 0, "R1 no access", 64'(acc_n), 64'd0);
        end else if (wl != rl) begin
            chk(err && !done && !busy && chan_state == 2'd2, "R2 size mismatch error", {62'd0, chan_state}, 64'd2);
            chk(exec_src == ps && exec_dst == pd && exec_bytes == pb, "R2 exec untouched", exec_src, ps);
            repeat (4) @(negedge clk);
            chk(acc_n == 0, "R2 no access", 64'(acc_n), 64'd0);
        end else begin
            chk(busy && !done && !err && chan_state == 2'd1 && exec_src == s && exec_dst == d &&
                exec_bytes == n && exec_wr_lg2 == wl && exec_rd_lg2 == rl && exec_repeat == rep,
                "R5 start load", exec_bytes, n);
            if (poke) begin
                repeat (3) @(negedge clk);
                desc_bytes = '0; desc_src = 64'h123; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(busy && !done && chan_state == 2'd1 && exec_wr_lg2 == wl, "R9 start ignored",
                    {63'd0, done}, 64'd0);
            end
            while (busy) @(negedge clk);
            chk(done && !err && chan_state == 2'd3, "R8 completion", {62'd0, chan_state}, 64'd3);
            if (rep)
                chk(exec_src == s && exec_dst == d && exec_bytes == n, "R7 repeat restore", exec_src, s);
            else
                chk(exec_src == s + n && exec_dst == d + n && exec_bytes == 0, "R7 no-repeat final", exec_src, s + n);
            ok = 1'b1;
            for (int i = 0; i < int'(n); i++)
                if (mem[(d + 64'(i)) % MEM_B] != gold[(s + 64'(i)) % MEM_B]) ok = 1'b0;
            chk(ok && mem[(d + n) % MEM_B] == gold[(d + n) % MEM_B], "R10 data copy", {63'd0, ok}, 64'd1);
            sz = full_sz(wl); nexp = 0; rem = n; ok = 1'b1;
            while (rem > 0) begin
                int unsigned l;
                l = (rem < sz) ? rem : sz;
                if (nexp >= rl_n || nexp >= wl_n || rlens[nexp] != l || wlens[nexp] != l) ok = 1'b0;
                nexp++; rem -= l;
            end
            chk(ok && rl_n == nexp && wl_n == nexp, "R4 R3 transaction lengths", 64'(rl_n), 64'(nexp));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_B; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !rd_valid && !wr_valid && chan_state == 2'd0,
            "R11 reset state", {62'd0, chan_state}, 64'd0);
        rst_n = 1'b1;
        run_xfer(64'd16, 64'd2100, 64'd0, 4'd3, 4'd3, 1'b0, 1'b0);
        run_xfer(64'd16, 64'd2100, 64'd40, 4'd3, 4'd4, 1'b0, 1'b0);
        run_xfer(64'd0, 64'd2048, 64'd64, 4'd6, 4'd6, 1'b0, 1'b0);
        run_xfer(64'd100, 64'd2300, 64'd100, 4'd9, 4'd9, 1'b0, 1'b0);
        run_xfer(64'd7, 64'd2501, 64'd13, 4'd3, 4'd3, 1'b0, 1'b0);
        run_xfer(64'd33, 64'd2600, 64'd5, 4'd4, 4'd4, 1'b0, 1'b0);
        run_xfer(64'd50, 64'd2700, 64'd7, 4'd0, 4'd0, 1'b0, 1'b0);
        run_xfer(64'd300, 64'd2800, 64'd50, 4'd4, 4'd4, 1'b1, 1'b0);
        run_xfer(64'd400, 64'd3000, 64'd120, 4'd2, 4'd2, 1'b0, 1'b1);
        run_xfer(64'd16, 64'd2100, 64'd0, 4'd3, 4'd3, 1'b0, 1'b0);
        for (int t = 0; t < 24; t++) begin
            logic [3:0] wl, rl;
            wl = 4'($urandom_range(0, 9));
            rl = ($urandom_range(0, 9) == 0) ? 4'(wl + 4'd1) : wl;
            run_xfer(64'($urandom_range(0, 1500)), 64'($urandom_range(2048, 3800)),
                     64'($urandom_range(0, 200)), wl, rl, 1'($urandom_range(0, 1)), 1'b0);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule